// File: doc/BRIEF.md
# Field-Bus Master Request Decoder and Slave Response Builder

This block sits behind the line receiver of a two-wire sensor/actuator field-bus slave. The physical layer has already removed the Manchester coding and presents one decoded bit per `bit_valid` strobe. The block collects the 14-bit master request. It checks the start bit, the end bit and the parity, and splits out the control bit, the 5-bit address and the 5-bit information field. It then reports whether the request is meant for this slave.

Two address schemes are supported. In normal mode only the five address bits are compared, which allows up to 31 slaves. In extended mode, information bit I3 also serves as an A/B select bit, which allows up to 62 slaves. That bit is then removed from the delivered information field, so only four information bits remain.

For the reply direction, the block frames four information bits into a 7-bit response. It sends that response out serially, most significant bit first.

Top module: `fieldbus_req_decoder`

## Requirements
- R1: Bits are taken only on cycles with `bit_valid` high. While no frame is in progress, a 1 bit is discarded as idle line. The first 0 bit starts a frame, and 14 accepted bits complete it.
- R2: In arrival order, a frame carries: start bit (0), control bit, address A4..A0, information I4..I0, parity bit, end bit (1). `req_ctrl`, `req_addr` and `req_info` present these fields, with A4 and I4 as the MSBs.
- R3: The parity bit makes the count of ones across the control, address, information and parity bits even. A frame that breaks this rule raises `req_err` and does not raise `req_valid` or `req_hit`.
- R4: A frame whose last bit is 0 raises `req_err` and does not raise `req_valid` or `req_hit`.
- R5: With `ext_mode` low, `req_hit` accompanies `req_valid` exactly when the address equals `my_addr`, whatever the value of I3. `req_info` then carries all five information bits.
- R6: With `ext_mode` high, `req_hit` also requires I3 to equal `my_sel`. `req_info` then carries {0, I4, I2, I1, I0}.
- R7: `req_valid` and `req_err` are single-cycle pulses. They appear in the second cycle after the clock edge that accepts the last bit of a frame.
- R8: `addr_default` is high exactly when `my_addr` is 0, the unprogrammed address.
- R9: A `rsp_load` while idle sends the frame 0, D3..D0, P, 1 on `rsp_bit`, MSB first, one bit per cycle. P makes the count of ones across D3..D0 and P even. `rsp_active` is high for exactly those 7 cycles, and `rsp_bit` is 1 otherwise.
- R10: A `rsp_load` while `rsp_active` is high is ignored, and the response in flight continues unchanged.
- R11: After reset, `req_valid`, `req_err`, `req_hit` and `rsp_active` are low and `rsp_bit` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_valid | input | 1 | A decoded bus bit is present on `bit_data` |
| bit_data | input | 1 | Decoded bus bit |
| ext_mode | input | 1 | 1 selects extended (A/B) addressing |
| my_addr | input | 5 | This slave's address |
| my_sel | input | 1 | This slave's A/B select value in extended mode |
| req_valid | output | 1 | Pulse: a well-formed request was received |
| req_err | output | 1 | Pulse: a request failed its framing or parity check |
| req_hit | output | 1 | Pulse: the well-formed request is addressed to this slave |
| req_ctrl | output | 1 | Control bit of the last good request (1 = command) |
| req_addr | output | 5 | Address of the last good request |
| req_info | output | 5 | Information field of the last good request |
| addr_default | output | 1 | `my_addr` is the default address 0 |
| rsp_load | input | 1 | Start sending a response |
| rsp_info | input | 4 | Response information bits |
| rsp_bit | output | 1 | Serial response bit |
| rsp_active | output | 1 | A response is being sent |

## Verification
The bench uses the default widths: a 5-bit address, a 5-bit information field with the select bit at position 3, and a 4-bit response. At these sizes, every one of the 32 addresses can be sent in both addressing modes with both select values. Every information value, a single-bit corruption at each of the twelve protected positions, and all 16 response values also fit in a short run. Every expected field, parity bit and hit decision is computed from the frame layout in the bench.

// File: rtl/frdec_pkg.sv
// Package: default field widths and the verdict type shared by the
// request decoder. Assumes the frame overheads are start, control,
// parity and end bits on requests, and start, parity and end on responses.
package frdec_pkg;
    localparam int DEF_ADDR_W   = 5;
    localparam int DEF_INFO_W   = 5;
    localparam int DEF_RSP_W    = 4;
    localparam int DEF_SEL_IDX  = 3;
    localparam int REQ_OVERHEAD = 4;
    localparam int RSP_OVERHEAD = 3;

    typedef enum logic [1:0] {
        VERDICT_NONE = 2'd0,
        VERDICT_GOOD = 2'd1,
        VERDICT_BAD  = 2'd2
    } verdict_e;
endpackage

// File: rtl/frdec_collect.sv
// frdec_collect: shifts decoded bus bits into a LEN-bit frame word.
// Assumes bit_valid marks one new bit per strobe. A 1 while idle is
// treated as an idle line. The completed word is flagged for one cycle.
module frdec_collect #(
    parameter int LEN = 14
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bit_valid,
    input  logic           bit_data,
    output logic           frame_done,
    output logic [LEN-1:0] frame
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0]  cnt;
    logic [LEN-1:0] sh;

    // Bit counter and shift register; a frame opens on the first 0 bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            sh         <= '0;
            frame_done <= 1'b0;
        end else begin
            frame_done <= 1'b0;
            if (bit_valid && !(cnt == '0 && bit_data)) begin
                sh <= {sh[LEN-2:0], bit_data};
                if (cnt == CW'(LEN - 1)) begin
                    cnt        <= '0;
                    frame_done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign frame = sh;
endmodule

// File: rtl/frdec_check.sv
// frdec_check: validates a completed request word and splits its fields.
// Assumes MSB-first order: start, control, address, info, parity, end.
// Outputs pulse for one cycle; the fields hold the last good frame.
module frdec_check
    import frdec_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int INFO_W  = DEF_INFO_W,
    parameter int SEL_IDX = DEF_SEL_IDX
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        frame_done,
    input  logic [ADDR_W+INFO_W+3:0]    frame,
    input  logic                        ext_mode,
    input  logic [ADDR_W-1:0]           my_addr,
    input  logic                        my_sel,
    output logic                        req_valid,
    output logic                        req_err,
    output logic                        req_hit,
    output logic                        req_ctrl,
    output logic [ADDR_W-1:0]           req_addr,
    output logic [INFO_W-1:0]           req_info
);
    localparam int LEN     = ADDR_W + INFO_W + REQ_OVERHEAD;
    localparam int CTRL_AT = LEN - 2;
    localparam int ADDR_HI = LEN - 3;
    localparam int INFO_HI = ADDR_HI - ADDR_W;

    logic              f_start, f_ctrl, f_end, par_even, addr_match;
    logic [ADDR_W-1:0] f_addr;
    logic [INFO_W-1:0] f_info, info_ext, info_out;
    verdict_e          verdict;

    // Field slicing and the framing/parity verdict.
    always_comb begin
        f_start  = frame[LEN-1];
        f_ctrl   = frame[CTRL_AT];
        f_addr   = frame[ADDR_HI -: ADDR_W];
        f_info   = frame[INFO_HI -: INFO_W];
        f_end    = frame[0];
        par_even = ~^frame[LEN-2:1];
        if (!frame_done)
            verdict = VERDICT_NONE;
        else if (!f_start && f_end && par_even)
            verdict = VERDICT_GOOD;
        else
            verdict = VERDICT_BAD;
    end

    // Extended-mode info field: drop the select bit, pad zero on top.
    always_comb begin
        info_ext = '0;
        for (int k = 0; k < INFO_W - 1; k++)
            info_ext[k] = (k < SEL_IDX) ? f_info[k] : f_info[k+1];
        info_out = ext_mode ? info_ext : f_info;
    end

    // Address compare, including the A/B select bit in extended mode.
    always_comb begin
        addr_match = (f_addr == my_addr) && (!ext_mode || f_info[SEL_IDX] == my_sel);
    end

    // Registered verdict pulses and held fields of the last good frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_valid <= 1'b0;
            req_err   <= 1'b0;
            req_hit   <= 1'b0;
            req_ctrl  <= 1'b0;
            req_addr  <= '0;
            req_info  <= '0;
        end else begin
            req_valid <= (verdict == VERDICT_GOOD);
            req_err   <= (verdict == VERDICT_BAD);
            req_hit   <= (verdict == VERDICT_GOOD) && addr_match;
            if (verdict == VERDICT_GOOD) begin
                req_ctrl <= f_ctrl;
                req_addr <= f_addr;
                req_info <= info_out;
            end
        end
    end
endmodule

// File: rtl/frdec_resp.sv
// frdec_resp: frames RSP_W info bits with start, even parity and end,
// and sends them MSB first. Assumes loads arriving mid-frame are dropped.
// The line idles at 1.
module frdec_resp
    import frdec_pkg::*;
#(
    parameter int RSP_W = DEF_RSP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rsp_load,
    input  logic [RSP_W-1:0] rsp_info,
    output logic             rsp_bit,
    output logic             rsp_active
);
    localparam int RLEN = RSP_W + RSP_OVERHEAD;
    localparam int CW   = $clog2(RLEN + 1);

    logic [RLEN-1:0] sh;
    logic [CW-1:0]   left;

    // Load a fresh frame when idle, otherwise shift one bit per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '1;
            left <= '0;
        end else if (left == '0) begin
            if (rsp_load) begin
                sh   <= {1'b0, rsp_info, ^rsp_info, 1'b1};
                left <= CW'(RLEN);
            end
        end else begin
            sh   <= {sh[RLEN-2:0], 1'b1};
            left <= left - 1'b1;
        end
    end

    assign rsp_bit    = sh[RLEN-1];
    assign rsp_active = (left != '0);
endmodule

// File: rtl/fieldbus_req_decoder.sv
// fieldbus_req_decoder: top level of the request decoder and response
// sender. Assumes Manchester decoding happens upstream. The control bit
// is passed out as is; the command meaning is decoded elsewhere.
module fieldbus_req_decoder
    import frdec_pkg::*;
#(
    parameter int ADDR_W  = DEF_ADDR_W,
    parameter int INFO_W  = DEF_INFO_W,
    parameter int SEL_IDX = DEF_SEL_IDX,
    parameter int RSP_W   = DEF_RSP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_data,
    input  logic              ext_mode,
    input  logic [ADDR_W-1:0] my_addr,
    input  logic              my_sel,
    output logic              req_valid,
    output logic              req_err,
    output logic              req_hit,
    output logic              req_ctrl,
    output logic [ADDR_W-1:0] req_addr,
    output logic [INFO_W-1:0] req_info,
    output logic              addr_default,
    input  logic              rsp_load,
    input  logic [RSP_W-1:0]  rsp_info,
    output logic              rsp_bit,
    output logic              rsp_active
);
    localparam int LEN = ADDR_W + INFO_W + REQ_OVERHEAD;

    logic           frame_done;
    logic [LEN-1:0] frame;

    frdec_collect #(.LEN(LEN)) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_valid  (bit_valid),
        .bit_data   (bit_data),
        .frame_done (frame_done),
        .frame      (frame)
    );

    frdec_check #(.ADDR_W(ADDR_W), .INFO_W(INFO_W), .SEL_IDX(SEL_IDX)) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .frame_done (frame_done),
        .frame      (frame),
        .ext_mode   (ext_mode),
        .my_addr    (my_addr),
        .my_sel     (my_sel),
        .req_valid  (req_valid),
        .req_err    (req_err),
        .req_hit    (req_hit),
        .req_ctrl   (req_ctrl),
        .req_addr   (req_addr),
        .req_info   (req_info)
    );

    frdec_resp #(.RSP_W(RSP_W)) u_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .rsp_load   (rsp_load),
        .rsp_info   (rsp_info),
        .rsp_bit    (rsp_bit),
        .rsp_active (rsp_active)
    );

    // Flag for the unprogrammed default address.
    assign addr_default = (my_addr == '0);
endmodule

// File: rtl/fieldbus_req_decoder_chk.sv
// fieldbus_req_decoder_chk: temporal properties of the decoder ports.
// Assumes it is attached by the bind statement below. It keeps its own
// count of response length.
module fieldbus_req_decoder_chk #(
    parameter int INFO_W = 5,
    parameter int RSP_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ext_mode,
    input logic              req_valid,
    input logic              req_err,
    input logic              req_hit,
    input logic [INFO_W-1:0] req_info,
    input logic              rsp_bit,
    input logic              rsp_active
);
    localparam int RLEN = RSP_W + 3;

    logic [7:0] run;

    // Count the consecutive cycles during which the response is active.
    always_ff @(posedge clk) begin
        if (!rst_n)          run <= '0;
        else if (rsp_active) run <= run + 1'b1;
        else                 run <= '0;
    end

    AST_GOOD_BAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_err)); // R3
    AST_HIT_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
        req_hit |-> req_valid); // R4
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid); // R7
    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_err |=> !req_err); // R7
    AST_EXT_INFO_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && ext_mode && $stable(ext_mode)) |-> (req_info[INFO_W-1] == 1'b0)); // R6
    AST_RSP_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_active) |-> (rsp_bit == 1'b0)); // R9
    AST_RSP_END: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rsp_active) |-> ($past(rsp_bit) == 1'b1)); // R9
    AST_RSP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rsp_active) |-> (run == 8'(RLEN))); // R10
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_active |-> rsp_bit); // R9
endmodule

bind fieldbus_req_decoder fieldbus_req_decoder_chk #(.INFO_W(INFO_W), .RSP_W(RSP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode   (ext_mode),
    .req_valid  (req_valid),
    .req_err    (req_err),
    .req_hit    (req_hit),
    .req_info   (req_info),
    .rsp_bit    (rsp_bit),
    .rsp_active (rsp_active)
);

// File: tb/test_fieldbus_req_decoder.sv
// test_fieldbus_req_decoder: sweeps addresses, modes, information values,
// corrupted bits and response values; expected values are built here.
module test_fieldbus_req_decoder;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_valid = 1'b0, bit_data = 1'b1;
    logic       ext_mode = 1'b0;
    logic [4:0] my_addr = 5'd19;
    logic       my_sel = 1'b1;
    logic       req_valid, req_err, req_hit, req_ctrl, addr_default;
    logic [4:0] req_addr, req_info;
    logic       rsp_load = 1'b0;
    logic [3:0] rsp_info = 4'd0;
    logic       rsp_bit, rsp_active;

    int vectors = 0;
    int fails   = 0;

    always #5 clk = ~clk;

    fieldbus_req_decoder i_fieldbus_req_decoder (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_data(bit_data),
        .ext_mode(ext_mode), .my_addr(my_addr), .my_sel(my_sel),
        .req_valid(req_valid), .req_err(req_err), .req_hit(req_hit),
        .req_ctrl(req_ctrl), .req_addr(req_addr), .req_info(req_info),
        .addr_default(addr_default), .rsp_load(rsp_load), .rsp_info(rsp_info),
        .rsp_bit(rsp_bit), .rsp_active(rsp_active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [13:0] mk_frame(input logic cb, input logic [4:0] a, input logic [4:0] i);
        return {1'b0, cb, a, i, ^{cb, a, i}, 1'b1};
    endfunction

    // Send 14 bits MSB first and stop at the cycle where the verdict pulses.
    task automatic send(input logic [13:0] f);
        for (int k = 13; k >= 0; k--) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_data  = f[k];
        end
        @(negedge clk);
        bit_valid = 1'b0;
        bit_data  = 1'b1;
        @(negedge clk);
    endtask

    task automatic good_frame(input logic cb, input logic [4:0] a, input logic [4:0] i);
        logic       hit;
        logic [4:0] info;
        hit  = (a == my_addr) && (!ext_mode || i[3] == my_sel);
        info = ext_mode ? {1'b0, i[4], i[2:0]} : i;
        send(mk_frame(cb, a, i));
        check("R2 valid", req_valid, 1);
        check("R3 no err", req_err, 0);
        check(ext_mode ? "R6 hit" : "R5 hit", req_hit, hit);
        check("R2 ctrl", req_ctrl, cb);
        check("R2 addr", req_addr, a);
        check(ext_mode ? "R6 info" : "R5 info", req_info, info);
        @(negedge clk);
        check("R7 pulse width", {req_valid, req_err}, 0);
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R11 valid", req_valid, 0);
        check("R11 err", req_err, 0);
        check("R11 hit", req_hit, 0);
        check("R11 active", rsp_active, 0);
        check("R11 bit", rsp_bit, 1);

        // Address / mode / select sweep
        for (int m = 0; m < 2; m++)
            for (int s = 0; s < 2; s++)
                for (int a = 0; a < 32; a++) begin
                    ext_mode = m[0];
                    good_frame(a[0], a[4:0], {a[1], s[0], a[4:2]});
                end

        // Information sweep at own address, both modes
        for (int m = 0; m < 2; m++)
            for (int i = 0; i < 32; i++) begin
                ext_mode = m[0];
                good_frame(i[2], my_addr, i[4:0]);
            end
        ext_mode = 1'b0;

        // Single-bit corruption of each parity-protected position
        for (int p = 1; p <= 12; p++) begin
            logic [13:0] f;
            f = mk_frame(1'b1, my_addr, 5'h0A);
            f[p] = ~f[p];
            send(f);
            check("R3 err", req_err, 1);
            check("R3 no valid", req_valid, 0);
            check("R3 no hit", req_hit, 0);
            @(negedge clk);
            check("R7 err pulse", req_err, 0);
        end

        // End bit cleared
        begin
            logic [13:0] f;
            f = mk_frame(1'b0, my_addr, 5'h11);
            f[0] = 1'b0;
            send(f);
            check("R4 err", req_err, 1);
            check("R4 no valid", req_valid, 0);
            check("R4 no hit", req_hit, 0);
        end

        // Idle ones ahead of a frame are discarded
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            bit_valid = 1'b1;
            bit_data  = 1'b1;
        end
        good_frame(1'b0, my_addr, 5'h15);
        check("R1 no spurious", {req_valid, req_err}, 0);

        // Default address
        check("R8 nonzero", addr_default, 0);
        my_addr = 5'd0;
        @(negedge clk);
        check("R8 zero", addr_default, 1);
        good_frame(1'b1, 5'd0, 5'h07);
        my_addr = 5'd19;

        // Response frames with a load attempt mid-frame
        for (int v = 0; v < 16; v++) begin
            logic [6:0] exp;
            exp = {1'b0, v[3:0], ^v[3:0], 1'b1};
            @(negedge clk);
            rsp_load = 1'b1;
            rsp_info = v[3:0];
            @(negedge clk);
            rsp_load = 1'b0;
            for (int k = 6; k >= 0; k--) begin
                check("R9 bit", rsp_bit, exp[k]);
                check("R9 active", rsp_active, 1);
                if (k == 4) begin
                    rsp_load = 1'b1;
                    rsp_info = ~v[3:0];
                end else begin
                    rsp_load = 1'b0;
                end
                @(negedge clk);
            end
            check("R10 ended", rsp_active, 0);
            check("R9 idle", rsp_bit, 1);
        end

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule